// File: doc/BRIEF.md
# Pulse Generator Timer Channel

This block is one channel of a periodic pulse generator. A reloadable downcounter counts count-enable strobes. When it is at zero and another strobe arrives, it underflows: it reloads from a cycle register, toggles an output level and raises a borrow flag. Software can clear the flag. The flag can request an interrupt, and the output level can be driven onto a pin in place of general-purpose I/O.

A mode register sets the counting behaviour. In independent 8-bit mode, the channel counts one of eight clock strobes chosen by a 3-bit select field. In prescaler mode, it counts the underflows of a partner channel. In cascaded 16-bit mode, it also counts the partner's underflows and serves as the upper half of a wider counter. In that mode it neither sets its borrow flag nor toggles its level. The partner channel exists only as an input strobe. This channel's underflow is brought out on a port so that a partner can use it.

Registers are reached over a simple bus with a two-bit address, a write strobe, a read strobe and a read-modify-write qualifier. Reads are combinational.

Top module: `ppg_channel`

## Requirements
- R1: After reset, every control, cycle and mode field is 0, `irq` is 0, and the pin follows `gpio_out`/`gpio_oe`.
- R2: In the control register (address 0), bits 7:6 always read 0, and writing 1s to them changes nothing that can be read back.
- R3: `irq` is 1 exactly when the borrow flag (control bit 4) and the interrupt enable (control bit 5) are both 1.
- R4: In mode 0 (independent), the counter moves only on `tick[sel]`, where sel is control bits 2:0. A strobe while the count is 0 pulses `uf_out` in that cycle, sets the flag and reloads the cycle register (address 1). Underflows are therefore cycle+1 strobes apart.
- R5: In mode 1 (prescaler), the counter moves only on `partner_uf`, `tick` is ignored, and an underflow sets the flag.
- R6: In modes 2 and 3 (cascaded), an underflow pulses `uf_out` but neither sets the flag nor toggles the output level.
- R7: Writing 0 to control bit 4 clears the flag. Writing 1 to it leaves the flag unchanged.
- R8: A read of the control register with `bus_rmw` high returns bit 4 as 1. The other bits read their real values.
- R9: If an underflow and a write of 0 to the flag fall in the same cycle, the flag ends up set.
- R10: With output enable (control bit 3) at 0, `pin_out`=`gpio_out` and `pin_oe`=`gpio_oe`. At 1, `pin_oe`=1 and `pin_out` is the output level.
- R11: The output level is mode register (address 2) bit 2. A write there sets the level directly. In modes 0 and 1, each underflow inverts it. Mode bits 1:0 hold the mode code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_rmw | input | 1 | Read belongs to a read-modify-write access |
| bus_addr | input | 2 | Register address: 0 control, 1 cycle, 2 mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| tick | input | 8 | Count-enable strobes for the clock select |
| partner_uf | input | 1 | Underflow strobe of the partner channel |
| gpio_out | input | 1 | General-purpose output value |
| gpio_oe | input | 1 | General-purpose output enable |
| uf_out | output | 1 | Underflow pulse of this channel |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardest case to reach from the ports is an underflow that coincides with a software clear of the flag. The bench resets the channel so the count is known to be zero, then raises the selected strobe and a write of 0 to the flag bit in the same cycle. The cascaded mode's silence is also hard to observe. The bench watches `uf_out` to prove that an underflow really happened while the flag and pin level stayed put. To show that the wrong strobes are ignored, it counts strobes to the point where the next underflow must land and checks that it lands there.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    typedef enum logic [1:0] {
        MODE_IND   = 2'd0,
        MODE_PRE   = 2'd1,
        MODE_CASC  = 2'd2,
        MODE_CASCB = 2'd3
    } mode_e;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       ie;
        logic       flag;
        logic       oe;
        logic [2:0] sel;
    } ctrl_t;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_CYCLE = 2'd1;
    localparam logic [1:0] A_MODE  = 2'd2;

    localparam int FLAG_BIT = 4;
    localparam int LVL_BIT  = 2;

    function automatic logic is_casc(input mode_e m);
        return m[1];
    endfunction

    function automatic logic uses_partner(input mode_e m);
        return m != MODE_IND;
    endfunction

endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
    import ppg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic             rmw,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    input  logic             uf_set,
    input  logic             level,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] cycle,
    output mode_e            mode,
    output logic             lvl_wr,
    output logic             lvl_wdata,
    output logic [7:0]       rdata
);
    logic ctrl_wr, cyc_wr, mode_wr;

    assign ctrl_wr   = wr && addr == A_CTRL;
    assign cyc_wr    = wr && addr == A_CYCLE;
    assign mode_wr   = wr && addr == A_MODE;
    assign lvl_wr    = mode_wr;
    assign lvl_wdata = wdata[LVL_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            cycle <= '0;
            mode  <= MODE_IND;
        end else begin
            if (ctrl_wr) begin
                ctrl.ie  <= wdata[5];
                ctrl.oe  <= wdata[3];
                ctrl.sel <= wdata[2:0];
            end
            if (uf_set)
                ctrl.flag <= 1'b1;
            else if (ctrl_wr && !wdata[FLAG_BIT])
                ctrl.flag <= 1'b0;
            if (cyc_wr)
                cycle <= wdata[CNT_W-1:0];
            if (mode_wr)
                mode <= mode_e'(wdata[1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                A_CTRL:  rdata = {2'b00, ctrl.ie, ctrl.flag | rmw, ctrl.oe, ctrl.sel};
                A_CYCLE: rdata = 8'(cycle);
                A_MODE:  rdata = {5'b0, level, mode};
                default: rdata = '0;
            endcase
        end
    end

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wdata[FLAG_BIT] && !uf_set) |=> !ctrl.flag);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        uf_set |=> ctrl.flag);

    // R2
    rsvd_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_CTRL) |-> rdata[7:6] == 2'b00);

    // R8
    rmw_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && rmw && addr == A_CTRL) |-> rdata[FLAG_BIT]);

endmodule

// File: rtl/ppg_counter.sv
module ppg_counter
    import ppg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3,
    localparam int NTICK = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTICK-1:0] tick,
    input  logic [SEL_W-1:0] sel,
    input  mode_e            mode,
    input  logic             partner_uf,
    input  logic [CNT_W-1:0] cycle,
    input  logic             lvl_wr,
    input  logic             lvl_wdata,
    output logic             uf,
    output logic             level
);
    logic [CNT_W-1:0] cnt;
    logic [NTICK-1:0] hit;
    logic             tick_sel, strobe, casc;

    for (genvar i = 0; i < NTICK; i++) begin : g_sel
        assign hit[i] = tick[i] && (sel == SEL_W'(i));
    end

    assign tick_sel = |hit;
    assign casc     = is_casc(mode);
    assign strobe   = uses_partner(mode) ? partner_uf : tick_sel;
    assign uf       = strobe && cnt == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            level <= 1'b0;
        end else begin
            if (strobe)
                cnt <= uf ? cycle : cnt - 1'b1;
            if (lvl_wr)
                level <= lvl_wdata;
            else if (uf && !casc)
                level <= ~level;
        end
    end

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && cnt == '0) |=> cnt == $past(cycle));

    // R6
    casc_level_chk: assert property (@(posedge clk) disable iff (rst)
        (casc && !lvl_wr) |=> $stable(level));

endmodule

// File: rtl/ppg_pinmux.sv
module ppg_pinmux (
    input  logic oe,
    input  logic level,
    input  logic gpio_out,
    input  logic gpio_oe,
    output logic pin_out,
    output logic pin_oe
);
    assign pin_out = oe ? level : gpio_out;
    assign pin_oe  = oe | gpio_oe;
endmodule

// File: rtl/ppg_channel.sv
module ppg_channel
    import ppg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3,
    localparam int NTICK = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_rmw,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [NTICK-1:0] tick,
    input  logic             partner_uf,
    input  logic             gpio_out,
    input  logic             gpio_oe,
    output logic             uf_out,
    output logic             irq,
    output logic             pin_out,
    output logic             pin_oe
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] cycle;
    mode_e            mode;
    logic             lvl_wr, lvl_wdata, level, uf, uf_set;

    assign uf_set = uf && !is_casc(mode);
    assign uf_out = uf;
    assign irq    = ctrl.flag && ctrl.ie;

    ppg_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .rmw(bus_rmw),
        .addr(bus_addr), .wdata(bus_wdata), .uf_set(uf_set), .level(level),
        .ctrl(ctrl), .cycle(cycle), .mode(mode), .lvl_wr(lvl_wr),
        .lvl_wdata(lvl_wdata), .rdata(bus_rdata)
    );

    ppg_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) cnt_i (
        .clk(clk), .rst(rst), .tick(tick), .sel(ctrl.sel[SEL_W-1:0]),
        .mode(mode), .partner_uf(partner_uf), .cycle(cycle),
        .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata), .uf(uf), .level(level)
    );

    ppg_pinmux pin_i (
        .oe(ctrl.oe), .level(level), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // R6
    flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.flag) |-> $past(uf && !is_casc(mode)));

    // R3
    irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl.ie && ctrl.flag));

    // R10
    pin_gpio_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.oe |-> (pin_out == gpio_out && pin_oe == gpio_oe));

endmodule

// File: tb/ppg_channel_tb_top.sv
`timescale 1ns/1ps
module ppg_channel_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr, bus_rd, bus_rmw;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [7:0] tick;
    logic       partner_uf, gpio_out, gpio_oe;
    logic       uf_out, irq, pin_out, pin_oe;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    ppg_channel dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .partner_uf(partner_uf), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .uf_out(uf_out), .irq(irq), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_rmw = 0; bus_addr = 0;
        bus_wdata = 0; tick = 0; partner_uf = 0; gpio_out = 0; gpio_oe = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic m, output logic [7:0] d);
        bus_rd = 1'b1; bus_rmw = m; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_rmw = 1'b0;
    endtask

    // pulse one tick line (k<8) or the partner strobe (k==8); return uf_out seen
    task automatic pulse(input int k, output logic seen);
        if (k == 8) partner_uf = 1'b1; else tick[k] = 1'b1;
        #1 seen = uf_out;
        @(negedge clk);
        tick = '0; partner_uf = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        gpio_out = 1'b1; gpio_oe = 1'b0;
        rd(2'd0, 1'b0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd1, 1'b0, d); chk("R1 cycle", d, 8'h00);
        rd(2'd2, 1'b0, d); chk("R1 mode", d, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 pin", {6'b0, pin_oe, pin_out}, 8'h01);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        do_reset();
        wr(2'd0, 8'hC0);
        rd(2'd0, 1'b0, d); chk("R2 rsvd only", d, 8'h00);
        wr(2'd0, 8'hE9);
        rd(2'd0, 1'b0, d); chk("R2 rsvd mixed", d, 8'h29);
    endtask

    task automatic t_independent();
        logic [7:0] d;
        logic s;
        do_reset();
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h03);
        pulse(3, s); chk("R4 first uf", {7'b0, s}, 8'h01);
        rd(2'd0, 1'b0, d); chk("R4 flag set", d, 8'h13);
        rd(2'd2, 1'b0, d); chk("R11 level toggled", d, 8'h04);
        wr(2'd0, 8'h03);
        // wrong strobes are ignored
        pulse(0, s); chk("R4 other tick", {7'b0, s}, 8'h00);
        pulse(7, s); chk("R4 other tick", {7'b0, s}, 8'h00);
        pulse(8, s); chk("R4 partner ignored", {7'b0, s}, 8'h00);
        pulse(3, s); chk("R4 count 2", {7'b0, s}, 8'h00);
        pulse(3, s); chk("R4 count 1", {7'b0, s}, 8'h00);
        rd(2'd0, 1'b0, d); chk("R4 no flag early", d, 8'h03);
        pulse(3, s); chk("R4 period uf", {7'b0, s}, 8'h01);
        rd(2'd2, 1'b0, d); chk("R11 level back", d, 8'h00);
    endtask

    task automatic t_irq_flag();
        logic [7:0] d;
        logic s;
        do_reset();
        wr(2'd0, 8'h00);
        pulse(0, s);
        chk("R3 flag no ie", {7'b0, irq}, 8'h00);
        wr(2'd0, 8'h30);
        chk("R3 flag and ie", {7'b0, irq}, 8'h01);
        chk("R7 write 1 keeps", {7'b0, irq}, 8'h01);
        rd(2'd0, 1'b0, d); chk("R7 flag kept", d, 8'h30);
        rd(2'd0, 1'b1, d); chk("R8 rmw set flag", d, 8'h30);
        wr(2'd0, 8'h20);
        chk("R3 cleared irq", {7'b0, irq}, 8'h00);
        rd(2'd0, 1'b0, d); chk("R7 cleared", d, 8'h20);
        rd(2'd0, 1'b1, d); chk("R8 rmw reads 1", d, 8'h30);
        rd(2'd0, 1'b0, d); chk("R8 rmw no side effect", d, 8'h20);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        do_reset();
        tick[0] = 1'b1;
        wr(2'd0, 8'h00);
        tick = '0;
        rd(2'd0, 1'b0, d); chk("R9 set wins", d, 8'h10);
    endtask

    task automatic t_prescaler();
        logic [7:0] d;
        logic s;
        do_reset();
        wr(2'd1, 8'd1);
        wr(2'd2, 8'h01);
        pulse(8, s); chk("R5 first uf", {7'b0, s}, 8'h01);
        rd(2'd0, 1'b0, d); chk("R5 flag", d, 8'h10);
        wr(2'd0, 8'h00);
        pulse(0, s); chk("R5 tick ignored", {7'b0, s}, 8'h00);
        pulse(0, s); chk("R5 tick ignored", {7'b0, s}, 8'h00);
        pulse(8, s); chk("R5 count", {7'b0, s}, 8'h00);
        pulse(8, s); chk("R5 period uf", {7'b0, s}, 8'h01);
    endtask

    task automatic t_cascade();
        logic [7:0] d;
        logic s;
        do_reset();
        wr(2'd2, 8'h02);
        wr(2'd0, 8'h08);
        pulse(8, s); chk("R6 uf pulses", {7'b0, s}, 8'h01);
        rd(2'd0, 1'b0, d); chk("R6 no flag", d, 8'h08);
        chk("R6 level held", {7'b0, pin_out}, 8'h00);
        wr(2'd2, 8'h07);
        chk("R11 level written", {7'b0, pin_out}, 8'h01);
        pulse(8, s); chk("R6 uf mode3", {7'b0, s}, 8'h01);
        rd(2'd0, 1'b0, d); chk("R6 no flag mode3", d, 8'h08);
        chk("R6 level held mode3", {7'b0, pin_out}, 8'h01);
    endtask

    task automatic t_pin();
        do_reset();
        gpio_out = 1'b0; gpio_oe = 1'b1;
        #1 chk("R10 gpio", {6'b0, pin_oe, pin_out}, 8'h02);
        gpio_out = 1'b1; gpio_oe = 1'b0;
        #1 chk("R10 gpio2", {6'b0, pin_oe, pin_out}, 8'h01);
        @(negedge clk);
        wr(2'd0, 8'h08);
        chk("R10 oe low level", {6'b0, pin_oe, pin_out}, 8'h02);
        wr(2'd2, 8'h04);
        chk("R10 oe high level", {6'b0, pin_oe, pin_out}, 8'h03);
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        t_reserved();
        t_independent();
        t_irq_flag();
        t_set_wins();
        t_prescaler();
        t_cascade();
        t_pin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule